// File: doc/BRIEF.md
# UART register command handler

This block sits between a byte-wide UART receiver and a UART transmitter. It turns short ASCII text commands into accesses to a small register space and sends a reply for each one. Every command carries a 16-bit address written as four hex digits, and every data value is 16 bits wide. A write returns a two-letter acknowledgement. A read of an ordinary register returns its value as hex text.

Two addresses are special. Address 0x0000 holds a fixed version word that cannot be written. A read of address 0x0001 does not return a single word: it starts a bulk dump of the captured sample buffer as raw binary bytes. The dump reads the sample memory through an address/channel port. In dual-channel mode it interleaves two capture channels.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: After reset `tx_valid` is low and nothing is transmitted until a complete command has been received.
- R2: A read is the bytes 'R' (0x52), space (0x20), four hex digits and carriage return (0x0D). For a mapped register the reply is the value as four uppercase hex digits, most significant first, followed by 0x0D.
- R3: A write is 'W' (0x57), space, four hex address digits, space, four hex data digits and 0x0D. The scratch registers at 0x0010 to 0x0013 (reset value 0x0000, each independent) take the data, and the reply is 'O' 'K' (0x4F 0x4B) with no terminator.
- R4: Hex digits in both address and data are accepted in upper case (A-F) and lower case (a-f).
- R5: Address 0x0000 reads as {family[15:12], major[11:8], minor[7:0]}, which is 0x2100 by default. A write to it replies 'E' 'R' (0x45 0x52) and leaves the value unchanged.
- R6: A read of 0x0001 sends 4096 samples, sample k read from channel 0 at buffer address k. Each sample goes out as two raw bytes, high byte first, and there is no trailing terminator.
- R7: When `dual_mode` is high at the moment the dump starts, 8192 samples are sent. Position k comes from channel (k mod 2) at buffer address k/2, so even positions use channel 0 and odd positions channel 1.
- R8: Any byte that breaks the command syntax produces the reply 'E' 'R' at once and returns the parser to idle, so that the next well-formed command is handled normally.
- R9: A read of an address outside {0x0000, 0x0001, 0x0010..0x0013}, or a write to any address outside 0x0010..0x0013, replies 'E' 'R'.
- R10: Each reply byte is held stable on `tx_byte` with `tx_valid` high until the transmitter accepts it (`tx_valid` and `tx_ready` both high on a clock edge). Only then does the next byte appear.
- R11: Received bytes that arrive while a reply or dump is being sent are discarded. They change no register and produce no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | A reply byte is offered |
| tx_byte | output | 8 | Reply byte |
| dual_mode | input | 1 | Dump interleaves two channels when high |
| mem_addr | output | 12 | Sample buffer address for the dump |
| mem_chan | output | 1 | Sample buffer channel for the dump |
| mem_rdata | input | 16 | Sample word, combinational from mem_addr/mem_chan |

## Verification
Reads and writes are driven with upper-case and lower-case hex, so a digit decoder that handles only one case shows up. Malformed lines are cut off at different positions: a bad lead letter, a bad hex digit, a missing separator and an early carriage return. Each must yield exactly one error reply and then a working parser. Dumps are run in single and dual mode against a memory whose words differ per channel and per address, which exposes a swapped byte order, a wrong channel interleave or a wrong sample count. The transmitter ready line stalls on a fixed pattern throughout, and a write is injected in the middle of a dump; a later readback and the absence of any stray reply show that the write was discarded.

// File: rtl/ucmd_pkg.sv
package ucmd_pkg;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_SP = 8'h20;
  localparam logic [7:0] CH_R  = 8'h52;
  localparam logic [7:0] CH_W  = 8'h57;
  localparam logic [7:0] CH_O  = 8'h4F;
  localparam logic [7:0] CH_K  = 8'h4B;
  localparam logic [7:0] CH_E  = 8'h45;

  typedef enum logic [1:0] {RSP_WORD, RSP_OK, RSP_ERR, RSP_DUMP} rsp_kind_t;

  // Digit test for 0-9, A-F, a-f
  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] t;
    if (c <= 8'h39)      t = c - 8'h30;
    else if (c <= 8'h46) t = c - 8'h37;
    else                 t = c - 8'h57;
    return t[3:0];
  endfunction

  // Upper-case ASCII for a nibble
  function automatic logic [7:0] nib_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/ucmd_parser.sv
module ucmd_parser
  import ucmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        busy,
  output logic        rd_fire,
  output logic        wr_fire,
  output logic        err_fire,
  output logic [15:0] cmd_addr,
  output logic [15:0] cmd_data
);
  logic [3:0]  pos, pos_n;
  logic        is_wr, is_wr_n;
  logic [15:0] addr_n, data_n;
  logic        rd_e, wr_e, er_e, bad;
  logic        take;

  assign take = rx_valid && !busy;

  always_comb begin
    pos_n   = pos;
    is_wr_n = is_wr;
    addr_n  = cmd_addr;
    data_n  = cmd_data;
    rd_e    = 1'b0;
    wr_e    = 1'b0;
    er_e    = 1'b0;
    bad     = 1'b0;
    if (take) begin
      if (pos == 4'd0) begin
        if (rx_byte == CH_R)      is_wr_n = 1'b0;
        else if (rx_byte == CH_W) is_wr_n = 1'b1;
        else                      bad = 1'b1;
      end else if (pos == 4'd1 || (pos == 4'd6 && is_wr)) begin
        bad = (rx_byte != CH_SP);
      end else if (pos >= 4'd2 && pos <= 4'd5) begin
        bad    = !is_hex(rx_byte);
        addr_n = {cmd_addr[11:0], hex_val(rx_byte)};
      end else if (pos >= 4'd7 && pos <= 4'd10) begin
        bad    = !is_hex(rx_byte);
        data_n = {cmd_data[11:0], hex_val(rx_byte)};
      end else begin
        bad = (rx_byte != CH_CR);
      end
      if (bad) begin
        er_e  = 1'b1;
        pos_n = 4'd0;
      end else if (pos == 4'd6 && !is_wr) begin
        rd_e  = 1'b1;
        pos_n = 4'd0;
      end else if (pos == 4'd11) begin
        wr_e  = 1'b1;
        pos_n = 4'd0;
      end else begin
        pos_n = pos + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      is_wr    <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
      rd_fire  <= 1'b0;
      wr_fire  <= 1'b0;
      err_fire <= 1'b0;
    end else begin
      pos      <= pos_n;
      is_wr    <= is_wr_n;
      cmd_addr <= addr_n;
      cmd_data <= data_n;
      rd_fire  <= rd_e;
      wr_fire  <= wr_e;
      err_fire <= er_e;
    end
  end

  // R8: one command outcome per cycle at most
  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_fire, wr_fire, err_fire}));
  // R11: bytes seen while busy leave the parse position untouched
  p_drop_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pos));
endmodule

// File: rtl/ucmd_responder.sv
module ucmd_responder
  import ucmd_pkg::*;
#(
  parameter int SAMPLES = 4096,
  localparam int AW = $clog2(SAMPLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  rsp_kind_t     kind,
  input  logic [15:0]   word,
  input  logic          dual_mode,
  input  logic          tx_ready,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] mem_addr,
  output logic          mem_chan,
  output logic          busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEQ, ST_DUMP} st_t;
  localparam logic [AW:0] LAST1 = (AW+1)'(SAMPLES - 1);
  localparam logic [AW:0] LAST2 = (AW+1)'(2 * SAMPLES - 1);

  st_t        state;
  logic [7:0] seq_b [5];
  logic [2:0] seq_len, seq_idx;
  logic [AW:0] samp;
  logic       phase, dual_q;
  logic       tx_acc, samp_last;

  assign busy      = (state != ST_IDLE);
  assign tx_valid  = busy;
  assign tx_acc    = tx_valid && tx_ready;
  assign samp_last = dual_q ? (samp == LAST2) : (samp == LAST1);
  assign mem_addr  = dual_q ? samp[AW:1] : samp[AW-1:0];
  assign mem_chan  = dual_q & samp[0];

  always_comb begin
    case (state)
      ST_DUMP: tx_byte = phase ? mem_rdata[7:0] : mem_rdata[15:8];
      ST_SEQ:  tx_byte = seq_b[seq_idx];
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      seq_len <= '0;
      seq_idx <= '0;
      samp    <= '0;
      phase   <= 1'b0;
      dual_q  <= 1'b0;
      for (int i = 0; i < 5; i++) seq_b[i] <= 8'h00;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          seq_idx <= '0;
          case (kind)
            RSP_WORD: begin
              seq_b[0] <= nib_ascii(word[15:12]);
              seq_b[1] <= nib_ascii(word[11:8]);
              seq_b[2] <= nib_ascii(word[7:4]);
              seq_b[3] <= nib_ascii(word[3:0]);
              seq_b[4] <= CH_CR;
              seq_len  <= 3'd5;
              state    <= ST_SEQ;
            end
            RSP_OK: begin
              seq_b[0] <= CH_O;
              seq_b[1] <= CH_K;
              seq_len  <= 3'd2;
              state    <= ST_SEQ;
            end
            RSP_ERR: begin
              seq_b[0] <= CH_E;
              seq_b[1] <= CH_R;
              seq_len  <= 3'd2;
              state    <= ST_SEQ;
            end
            default: begin
              samp   <= '0;
              phase  <= 1'b0;
              dual_q <= dual_mode;
              state  <= ST_DUMP;
            end
          endcase
        end
        ST_SEQ: if (tx_acc) begin
          if (seq_idx == seq_len - 3'd1) state <= ST_IDLE;
          seq_idx <= seq_idx + 3'd1;
        end
        ST_DUMP: if (tx_acc) begin
          phase <= ~phase;
          if (phase) begin
            samp <= samp + 1'b1;
            if (samp_last) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an offered byte is held until accepted
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
  // R6: both bytes of one sample come from the same buffer location
  p_pair_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DUMP) && tx_acc && !phase |=> $stable(mem_addr) && $stable(mem_chan));
  // R7: single mode never touches the second channel
  p_single_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DUMP) && !dual_q |-> !mem_chan);
  // R11: a new reply is only ever started from idle
  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> state == ST_IDLE);
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import ucmd_pkg::*;
#(
  parameter int          SAMPLES  = 4096,
  parameter int          NUM_REGS = 4,
  parameter logic [15:0] REG_BASE = 16'h0010,
  parameter logic [3:0]  FAMILY   = 4'h2,
  parameter logic [3:0]  VER_MAJ  = 4'h1,
  parameter logic [7:0]  VER_MIN  = 8'h00,
  localparam int AW = $clog2(SAMPLES),
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          dual_mode,
  output logic [AW-1:0] mem_addr,
  output logic          mem_chan,
  input  logic [15:0]   mem_rdata
);
  localparam logic [15:0] VER_WORD  = {FAMILY, VER_MAJ, VER_MIN};
  localparam logic [15:0] VER_ADDR  = 16'h0000;
  localparam logic [15:0] DUMP_ADDR = 16'h0001;

  logic        rd_fire, wr_fire, err_fire, busy;
  logic [15:0] cmd_addr, cmd_data, off;
  logic        hit, rsp_start;
  logic [IW-1:0] idx;
  rsp_kind_t   rsp_kind;
  logic [15:0] rsp_word;
  logic [15:0] regs [NUM_REGS];

  ucmd_parser u_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .busy(busy), .rd_fire(rd_fire), .wr_fire(wr_fire), .err_fire(err_fire),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  assign off = cmd_addr - REG_BASE;
  assign hit = (cmd_addr >= REG_BASE) && (off < 16'(NUM_REGS));
  assign idx = off[IW-1:0];
  assign rsp_start = rd_fire | wr_fire | err_fire;

  always_comb begin
    rsp_kind = RSP_ERR;
    rsp_word = 16'h0000;
    if (rd_fire) begin
      if (cmd_addr == VER_ADDR) begin
        rsp_kind = RSP_WORD;
        rsp_word = VER_WORD;
      end else if (cmd_addr == DUMP_ADDR) begin
        rsp_kind = RSP_DUMP;
      end else if (hit) begin
        rsp_kind = RSP_WORD;
        rsp_word = regs[idx];
      end
    end else if (wr_fire && hit) begin
      rsp_kind = RSP_OK;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  regs[g] <= 16'h0000;
      else if (wr_fire && hit && idx == IW'(g))    regs[g] <= cmd_data;
    end
  end

  ucmd_responder #(.SAMPLES(SAMPLES)) u_resp (
    .clk(clk), .rst_n(rst_n), .start(rsp_start), .kind(rsp_kind),
    .word(rsp_word), .dual_mode(dual_mode), .tx_ready(tx_ready),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .mem_addr(mem_addr), .mem_chan(mem_chan), .busy(busy)
  );

  // R3: a write never targets anything but the scratch window
  p_write_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !hit |-> rsp_kind == RSP_ERR);
  // R1: nothing is offered in the cycle right after reset
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !tx_valid);
endmodule

// File: tb/uart_cmd_ctrl_tb_top.sv
module uart_cmd_ctrl_tb_top;
  localparam int AW = 12;
  localparam int NSAMP = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b1, dual_mode = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_valid, mem_chan;
  logic [7:0] tx_byte;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata;

  always #5 clk = ~clk;

  uart_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .dual_mode(dual_mode), .mem_addr(mem_addr), .mem_chan(mem_chan),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] sample_of(input logic ch, input logic [AW-1:0] a);
    logic [15:0] w;
    w = {4'h0, a};
    return ch ? ((w * 16'd7) ^ 16'hA55A) : (w + 16'h3C00);
  endfunction
  assign mem_rdata = sample_of(mem_chan, mem_addr);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  string up_hex = "0123456789ABCDEF";
  string lo_hex = "0123456789abcdef";

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tx_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected byte got %h expected none", tx_byte);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (tx_byte !== e) begin
          errors++;
          $display("FAIL %s reply byte got %h expected %h", t, tx_byte, e);
        end
      end
    end
  end

  // R10: a stalled byte stays put
  logic stall_prev = 1'b0;
  logic [7:0] stall_byte = 8'h00;
  always @(negedge clk) begin
    if (rst_n && stall_prev) begin
      checks++;
      if (!(tx_valid && tx_byte === stall_byte)) begin
        errors++;
        $display("FAIL R10 held byte got %b/%h expected 1/%h", tx_valid, tx_byte, stall_byte);
      end
    end
    stall_prev = rst_n && tx_valid && !tx_ready;
    stall_byte = tx_byte;
  end

  task automatic put(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic exp_word(input logic [15:0] w, input string t);
    for (int i = 3; i >= 0; i--) put(up_hex[int'(w[i*4 +: 4])], t);
    put(8'h0D, t);
  endtask

  task automatic exp_ok(input string t);
    put(8'h4F, t); put(8'h4B, t);
  endtask

  task automatic exp_er(input string t);
    put(8'h45, t); put(8'h52, t);
  endtask

  task automatic exp_dump(input bit dual, input string t);
    int n;
    n = dual ? 2 * NSAMP : NSAMP;
    for (int k = 0; k < n; k++) begin
      logic [15:0] s;
      s = dual ? sample_of(k[0], AW'(k >> 1)) : sample_of(1'b0, AW'(k));
      put(s[15:8], t);
      put(s[7:0], t);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(posedge clk);
    #1 rx_valid = 1'b1; rx_byte = b;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic send_hex(input logic [15:0] v, input bit lower);
    for (int i = 3; i >= 0; i--)
      send(lower ? lo_hex[int'(v[i*4 +: 4])] : up_hex[int'(v[i*4 +: 4])]);
  endtask

  task automatic cmd_rd(input logic [15:0] a, input bit lower);
    send(8'h52); send(8'h20); send_hex(a, lower); send(8'h0D);
  endtask

  task automatic cmd_wr(input logic [15:0] a, input logic [15:0] d, input bit lower);
    send(8'h57); send(8'h20); send_hex(a, lower); send(8'h20);
    send_hex(d, lower); send(8'h0D);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 60000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (tx_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 tx_valid after reset got %b expected 0", tx_valid);
    end

    // R5 R2: version read
    exp_word(16'h2100, "R5"); cmd_rd(16'h0000, 1'b0); drain();
    // R3: write then read back, neighbour untouched
    exp_ok("R3"); cmd_wr(16'h0010, 16'h1234, 1'b0); drain();
    exp_word(16'h1234, "R2"); cmd_rd(16'h0010, 1'b0); drain();
    exp_word(16'h0000, "R3"); cmd_rd(16'h0011, 1'b0); drain();
    // R4: lower-case digits
    exp_ok("R4"); cmd_wr(16'h0012, 16'hBEEF, 1'b1); drain();
    exp_word(16'hBEEF, "R4"); cmd_rd(16'h0012, 1'b1); drain();
    exp_ok("R4"); cmd_wr(16'h0013, 16'hA0C9, 1'b0); drain();
    exp_word(16'hA0C9, "R4"); cmd_rd(16'h0013, 1'b1); drain();
    // R5: version is read-only
    exp_er("R5"); cmd_wr(16'h0000, 16'h5555, 1'b0); drain();
    exp_word(16'h2100, "R5"); cmd_rd(16'h0000, 1'b0); drain();
    // R9: unmapped addresses
    exp_er("R9"); cmd_rd(16'h0005, 1'b0); drain();
    exp_er("R9"); cmd_wr(16'h0001, 16'h0000, 1'b0); drain();
    exp_er("R9"); cmd_rd(16'h0014, 1'b0); drain();
    exp_er("R9"); cmd_wr(16'h000F, 16'h1111, 1'b0); drain();
    // R8: malformed lines at several positions
    exp_er("R8"); send(8'h51); drain();
    exp_er("R8"); send(8'h52); send(8'h20); send(8'h30); send(8'h30); send(8'h5A); drain();
    exp_er("R8"); send(8'h52); send(8'h2D); drain();
    exp_er("R8"); send(8'h57); send(8'h20); send_hex(16'h0010, 1'b0); send(8'h2D); drain();
    exp_er("R8"); send(8'h52); send(8'h20); send(8'h31); send(8'h32); send(8'h0D); drain();
    exp_word(16'h1234, "R8"); cmd_rd(16'h0010, 1'b0); drain();
    // R6: single-channel dump
    exp_dump(1'b0, "R6"); cmd_rd(16'h0001, 1'b0); drain();
    // R7: dual-channel dump
    dual_mode = 1'b1;
    exp_dump(1'b1, "R7"); cmd_rd(16'h0001, 1'b0); drain();
    dual_mode = 1'b0;
    // R11: write sent mid-dump is dropped
    exp_dump(1'b0, "R11"); cmd_rd(16'h0001, 1'b0);
    repeat (40) @(posedge clk);
    cmd_wr(16'h0010, 16'hFFFF, 1'b0);
    drain();
    exp_word(16'h1234, "R11"); cmd_rd(16'h0010, 1'b0); drain();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending replies got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule